// File: doc/BRIEF.md
# Discrete Line Controller with Edge Interrupts

This block manages two banks of discrete signals behind a small register bus. The first bank is a set of single-ended lines (14 by default), each of which software can make an input or an output. The second bank is a set of differential channels (8 by default); each channel's driver/receiver pair either belongs to a serial controller or is taken over as a discrete line. In serial mode the serial controller's transmit data reaches the driver and the receiver level reaches the serial controller. In discrete mode a register drives the driver, and the receiver is only read by software.

Every input, in either bank, passes through a synchroniser and then an edge detector. Software picks the edge per bit. A detected edge sets a sticky pending bit, which software clears by writing one. A per-bit enable mask selects which pending bits drive the single interrupt line. The register bus is a plain write strobe with an address. Reads are combinational from the address. The block has no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `discio_ctrl`

## Requirements
- R1: After reset every register reads 0, all single-ended lines are inputs (`se_pin_oe` = 0), every differential channel is in serial mode and `irq` is low.
- R2: Register map (word addresses): 0 direction, 1 output value, 2 level readback and 3 edge select for the single-ended bank; 4 pending and 5 enable mask for the single-ended bank; 6 channel mode, 7 discrete output value, 8 receiver level and 9 edge select for the differential bank; 10 pending and 11 enable mask for the differential bank. Bit n of each register belongs to line or channel n. Writes to 2 and 8, and to unused addresses, change nothing. Unused addresses read 0.
- R3: A direction bit of 1 makes that single-ended line an output. `se_pin_oe` equals the direction register and `se_pin_out` equals the output value register, one cycle after the write.
- R4: Reading address 2 returns, for output bits, the value being driven. For input bits it returns the pin level after a two-stage synchroniser, visible no later than the third clock edge after the pin changes.
- R5: For an input bit, an edge-select bit of 1 selects rising edges and 0 selects falling edges. A matching edge sets the pending bit once, and an edge of the other polarity sets nothing.
- R6: Bits configured as outputs never set their pending bit, whatever happens on the pin.
- R7: Writing 1 to a pending bit clears it and writing 0 leaves it alone. When an edge is detected in the same cycle as its clear, the bit stays set.
- R8: `irq` is high exactly when some pending bit in either bank is set and its mask bit is 1.
- R9: Channel mode bit 1 means discrete and 0 means serial. In discrete mode `df_tx_pin` follows the discrete output register. In serial mode it follows `ser_tx`, and the discrete output register has no effect on the pin.
- R10: Address 8 always shows the synchronised receiver level, whatever the mode. `ser_rx` carries the receiver level in serial mode and is held at 1 (idle) in discrete mode.
- R11: Differential receivers set their pending bits by the rules of R5, R7 and R8, but only while the channel is in discrete mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |
| se_pin_in | input | 14 | Single-ended line levels |
| se_pin_out | output | 14 | Single-ended drive values |
| se_pin_oe | output | 14 | Single-ended output enables |
| df_rx_pin | input | 8 | Differential receiver levels |
| df_tx_pin | output | 8 | Differential driver levels |
| ser_tx | input | 8 | Serial controller transmit data per channel |
| ser_rx | output | 8 | Receive data to the serial controller |
| irq | output | 1 | Combined interrupt |

## Verification
Random patterns of pin levels are applied under random direction, edge-select and mask settings. Each pattern is held long enough to be a single edge. This separates rising from falling detection, input bits from output bits and masked from unmasked pending bits. A random mode mix across the differential channels, with independent serial and register data, shows which source reaches each driver and whether serial-mode channels stay silent. Directed cases place an edge in exactly the cycle of its own clear, read back output bits against contrary pin levels, and check that pins held high through reset do not raise a false event.

// File: rtl/discio_pkg.sv
package discio_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;

  typedef enum logic [ADDR_W-1:0] {
    REG_SE_DIR  = 4'd0,
    REG_SE_OUT  = 4'd1,
    REG_SE_LVL  = 4'd2,
    REG_SE_EDGE = 4'd3,
    REG_SE_PEND = 4'd4,
    REG_SE_MASK = 4'd5,
    REG_DF_MODE = 4'd6,
    REG_DF_OUT  = 4'd7,
    REG_DF_LVL  = 4'd8,
    REG_DF_EDGE = 4'd9,
    REG_DF_PEND = 4'd10,
    REG_DF_MASK = 4'd11
  } reg_sel_e;
endpackage

// File: rtl/discio_sync.sv
module discio_sync #(
  parameter int W      = 14,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [STAGES-1:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) begin
        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/discio_edge_pend.sv
module discio_edge_pend #(
  parameter int W      = 14,
  parameter int SETTLE = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  input  logic [W-1:0] det_en,
  input  logic [W-1:0] rise_sel,
  input  logic         clr_we,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] pend
);
  localparam int CNT_W = $clog2(SETTLE + 1);

  logic [W-1:0]     prev_q;
  logic [W-1:0]     hit;
  logic [W-1:0]     clr_eff;
  logic [CNT_W-1:0] settle_q;
  logic             armed;

  // Detection stays off until the synchroniser and edge history agree after reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_q <= '0;
    end else if (settle_q != CNT_W'(SETTLE)) begin
      settle_q <= settle_q + 1'b1;
    end
  end
  assign armed = (settle_q == CNT_W'(SETTLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  genvar b;
  generate
    for (b = 0; b < W; b++) begin : g_bit
      assign hit[b] = armed && det_en[b] &&
                      (rise_sel[b] ? (lvl[b] && !prev_q[b]) : (!lvl[b] && prev_q[b]));
    end
  endgenerate

  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend <= '0;
    else        pend <= (pend & ~clr_eff) | hit;
  end

  // R5 / R7: a detected edge is always recorded, even against a clear
  p_edge_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit) |=> ((pend & $past(hit)) == $past(hit)));

  // R7: bits written with 1 and without a coincident edge drop
  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && ((clr_bits & hit) == '0)) |=> ((pend & $past(clr_bits)) == '0));

  // R6 / R11: a bit whose detection is off never becomes newly pending
  p_off_no_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(det_en)) == '0));
endmodule

// File: rtl/discio_diff_mux.sv
module discio_diff_mux #(
  parameter int W = 8
) (
  input  logic [W-1:0] disc_mode,
  input  logic [W-1:0] disc_out,
  input  logic [W-1:0] ser_tx,
  input  logic [W-1:0] rx_pin,
  output logic [W-1:0] tx_pin,
  output logic [W-1:0] ser_rx
);
  genvar c;
  generate
    for (c = 0; c < W; c++) begin : g_ch
      assign tx_pin[c] = disc_mode[c] ? disc_out[c] : ser_tx[c];
      assign ser_rx[c] = disc_mode[c] ? 1'b1 : rx_pin[c];
    end
  endgenerate
endmodule

// File: rtl/discio_ctrl.sv
module discio_ctrl
  import discio_pkg::*;
#(
  parameter int SE_W        = 14,
  parameter int DF_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [SE_W-1:0]   se_pin_in,
  output logic [SE_W-1:0]   se_pin_out,
  output logic [SE_W-1:0]   se_pin_oe,
  input  logic [DF_W-1:0]   df_rx_pin,
  output logic [DF_W-1:0]   df_tx_pin,
  input  logic [DF_W-1:0]   ser_tx,
  output logic [DF_W-1:0]   ser_rx,
  output logic              irq
);
  localparam int SETTLE = SYNC_STAGES + 1;

  logic [SE_W-1:0] se_dir_q, se_out_q, se_edge_q, se_mask_q;
  logic [DF_W-1:0] df_mode_q, df_out_q, df_edge_q, df_mask_q;
  logic [SE_W-1:0] se_sync, se_pend, se_view;
  logic [DF_W-1:0] df_sync, df_pend;
  logic            se_clr_we, df_clr_we;
  logic            wdata_unused;

  assign wdata_unused = &{1'b0, bus_wdata};

  // Configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      se_dir_q  <= '0;
      se_out_q  <= '0;
      se_edge_q <= '0;
      se_mask_q <= '0;
      df_mode_q <= '0;
      df_out_q  <= '0;
      df_edge_q <= '0;
      df_mask_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        REG_SE_DIR:  se_dir_q  <= bus_wdata[SE_W-1:0];
        REG_SE_OUT:  se_out_q  <= bus_wdata[SE_W-1:0];
        REG_SE_EDGE: se_edge_q <= bus_wdata[SE_W-1:0];
        REG_SE_MASK: se_mask_q <= bus_wdata[SE_W-1:0];
        REG_DF_MODE: df_mode_q <= bus_wdata[DF_W-1:0];
        REG_DF_OUT:  df_out_q  <= bus_wdata[DF_W-1:0];
        REG_DF_EDGE: df_edge_q <= bus_wdata[DF_W-1:0];
        REG_DF_MASK: df_mask_q <= bus_wdata[DF_W-1:0];
        default: ;
      endcase
    end
  end

  assign se_clr_we = bus_wr && (bus_addr == REG_SE_PEND);
  assign df_clr_we = bus_wr && (bus_addr == REG_DF_PEND);

  // Single-ended bank
  discio_sync #(.W(SE_W), .STAGES(SYNC_STAGES)) u_se_sync (
    .clk(clk), .rst_n(rst_n), .async_in(se_pin_in), .sync_out(se_sync)
  );

  discio_edge_pend #(.W(SE_W), .SETTLE(SETTLE)) u_se_edge (
    .clk(clk), .rst_n(rst_n), .lvl(se_sync), .det_en(~se_dir_q),
    .rise_sel(se_edge_q), .clr_we(se_clr_we),
    .clr_bits(bus_wdata[SE_W-1:0]), .pend(se_pend)
  );

  assign se_pin_oe  = se_dir_q;
  assign se_pin_out = se_out_q;
  assign se_view    = (se_dir_q & se_out_q) | (~se_dir_q & se_sync);

  // Differential bank
  discio_sync #(.W(DF_W), .STAGES(SYNC_STAGES)) u_df_sync (
    .clk(clk), .rst_n(rst_n), .async_in(df_rx_pin), .sync_out(df_sync)
  );

  discio_edge_pend #(.W(DF_W), .SETTLE(SETTLE)) u_df_edge (
    .clk(clk), .rst_n(rst_n), .lvl(df_sync), .det_en(df_mode_q),
    .rise_sel(df_edge_q), .clr_we(df_clr_we),
    .clr_bits(bus_wdata[DF_W-1:0]), .pend(df_pend)
  );

  discio_diff_mux #(.W(DF_W)) u_df_mux (
    .disc_mode(df_mode_q), .disc_out(df_out_q), .ser_tx(ser_tx),
    .rx_pin(df_rx_pin), .tx_pin(df_tx_pin), .ser_rx(ser_rx)
  );

  assign irq = (|(se_pend & se_mask_q)) | (|(df_pend & df_mask_q));

  // Read path
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      REG_SE_DIR:  bus_rdata = DATA_W'(se_dir_q);
      REG_SE_OUT:  bus_rdata = DATA_W'(se_out_q);
      REG_SE_LVL:  bus_rdata = DATA_W'(se_view);
      REG_SE_EDGE: bus_rdata = DATA_W'(se_edge_q);
      REG_SE_PEND: bus_rdata = DATA_W'(se_pend);
      REG_SE_MASK: bus_rdata = DATA_W'(se_mask_q);
      REG_DF_MODE: bus_rdata = DATA_W'(df_mode_q);
      REG_DF_OUT:  bus_rdata = DATA_W'(df_out_q);
      REG_DF_LVL:  bus_rdata = DATA_W'(df_sync);
      REG_DF_EDGE: bus_rdata = DATA_W'(df_edge_q);
      REG_DF_PEND: bus_rdata = DATA_W'(df_pend);
      REG_DF_MASK: bus_rdata = DATA_W'(df_mask_q);
      default:     bus_rdata = '0;
    endcase
  end

  // R3: output enables move only after a write to the direction register
  p_oe_after_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(se_pin_oe) |-> ($past(bus_wr) && ($past(bus_addr) == REG_SE_DIR)));
endmodule

// File: tb/sim_discio_ctrl.sv
module sim_discio_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [13:0] se_pin_in = '0;
  logic [13:0] se_pin_out, se_pin_oe;
  logic [7:0]  df_rx_pin = '0;
  logic [7:0]  df_tx_pin;
  logic [7:0]  ser_tx = '0;
  logic [7:0]  ser_rx;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  discio_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .se_pin_in(se_pin_in),
    .se_pin_out(se_pin_out), .se_pin_oe(se_pin_oe), .df_rx_pin(df_rx_pin),
    .df_tx_pin(df_tx_pin), .ser_tx(ser_tx), .ser_rx(ser_rx), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
  endtask

  function automatic logic [13:0] se_edges(input logic [13:0] dir, input logic [13:0] edg,
                                           input logic [13:0] pv, input logic [13:0] nw);
    return ~dir & ((edg & ~pv & nw) | (~edg & pv & ~nw));
  endfunction

  function automatic logic [7:0] df_edges(input logic [7:0] mode, input logic [7:0] edg,
                                          input logic [7:0] pv, input logic [7:0] nw);
    return mode & ((edg & ~pv & nw) | (~edg & pv & ~nw));
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] rv;
    logic [13:0] s_prev, s_new, s_dir, s_edge, s_mask, s_exp;
    logic [7:0]  d_prev, d_new, d_mode, d_edge, d_mask, d_out, d_exp, d_stx;
    int unused_seed;
    unused_seed = $urandom(32'h5EED);

    // R1: reset state, with some pins held high through reset
    se_pin_in = 14'h0005;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    settle();
    for (int a = 0; a < 12; a++) begin
      if (a == 2) continue;
      rd(a[3:0], rv);
      chk($sformatf("R1 reg%0d", a), rv, 0);
    end
    chk("R1 oe", se_pin_oe, 0);
    chk("R1 irq", irq, 0);
    chk("R1 serial tx", df_tx_pin, ser_tx);
    wr(4'd3, 16'h3FFF);
    settle();
    rd(4'd4, rv);
    chk("R1 no false edge after reset", rv, 0);
    wr(4'd3, 16'h0000);
    se_pin_in = '0;
    settle();
    wr(4'd4, 16'h3FFF);

    // R2: read-only and unused addresses ignore writes
    wr(4'd12, 16'hFFFF);
    rd(4'd12, rv);
    chk("R2 unused addr", rv, 0);
    wr(4'd2, 16'h3FFF);
    rd(4'd2, rv);
    chk("R2 level write ignored", rv, 0);

    // R3 / R4 / R6: outputs drive and read back their own value
    wr(4'd0, 16'h00FF);
    wr(4'd1, 16'h0F0F);
    chk("R3 oe", se_pin_oe, 14'h00FF);
    chk("R3 out", se_pin_out, 14'h0F0F);
    wr(4'd3, 16'h3FFF);
    @(negedge clk) se_pin_in = 14'h3FF0;
    settle();
    rd(4'd2, rv);
    chk("R4 level view", rv, 16'h3F0F);
    rd(4'd4, rv);
    chk("R6 outputs no pending", rv, 16'h3F00);
    wr(4'd4, 16'h3FFF);
    rd(4'd4, rv);
    chk("R7 clear all", rv, 0);

    // R5 random single-ended patterns
    s_prev = se_pin_in;
    for (int i = 0; i < 40; i++) begin
      s_dir = 14'($urandom); s_edge = 14'($urandom); s_mask = 14'($urandom);
      s_new = 14'($urandom);
      if (i % 4 == 0) s_dir = '0;
      wr(4'd0, {2'b0, s_dir});
      wr(4'd3, {2'b0, s_edge});
      wr(4'd5, {2'b0, s_mask});
      @(negedge clk) se_pin_in = s_new;
      settle();
      s_exp = se_edges(s_dir, s_edge, s_prev, s_new);
      rd(4'd4, rv);
      chk("R5 pending", rv, {2'b0, s_exp});
      chk("R8 irq", irq, |(s_exp & s_mask));
      rd(4'd2, rv);
      chk("R4 level", rv, {2'b0, (s_dir & se_pin_out) | (~s_dir & s_new)});
      wr(4'd4, 16'h3FFF);
      rd(4'd4, rv);
      chk("R7 cleared", rv, 0);
      s_prev = s_new;
    end

    // R7: edge in the cycle of its own clear
    wr(4'd0, 16'h0000);
    wr(4'd3, 16'h0600);
    @(negedge clk) se_pin_in = 14'h0000;
    settle();
    wr(4'd4, 16'h3FFF);
    @(negedge clk) se_pin_in = 14'h0600;
    settle();
    rd(4'd4, rv);
    chk("R5 two rising", rv, 16'h0600);
    wr(4'd3, 16'h0400);
    @(negedge clk) se_pin_in = 14'h0400;
    @(posedge clk);
    @(posedge clk);
    wr(4'd4, 16'h0600);
    rd(4'd4, rv);
    chk("R7 edge beats clear", rv, 16'h0200);

    // R8 masking
    wr(4'd5, 16'h0000);
    chk("R8 masked", irq, 0);
    wr(4'd5, 16'h0200);
    chk("R8 unmasked", irq, 1);
    wr(4'd5, 16'h01FF);
    chk("R8 other mask", irq, 0);
    wr(4'd4, 16'h3FFF);

    // R9 / R10 directed differential cases
    @(negedge clk) ser_tx = 8'hA5;
    wr(4'd7, 16'h00FF);
    chk("R9 serial ignores out reg", df_tx_pin, 8'hA5);
    wr(4'd6, 16'h000F);
    chk("R9 mixed tx", df_tx_pin, 8'hAF);
    @(negedge clk) df_rx_pin = 8'h3C;
    settle();
    chk("R10 ser_rx", ser_rx, 8'h3F);
    rd(4'd8, rv);
    chk("R10 level both modes", rv, 16'h003C);
    rd(4'd10, rv);
    chk("R11 falling only", rv, 0);

    // R11 random differential patterns
    d_prev = df_rx_pin;
    for (int i = 0; i < 40; i++) begin
      d_mode = 8'($urandom); d_edge = 8'($urandom); d_mask = 8'($urandom);
      d_out = 8'($urandom); d_stx = 8'($urandom); d_new = 8'($urandom);
      wr(4'd6, {8'b0, d_mode});
      wr(4'd9, {8'b0, d_edge});
      wr(4'd11, {8'b0, d_mask});
      wr(4'd7, {8'b0, d_out});
      @(negedge clk) begin df_rx_pin = d_new; ser_tx = d_stx; end
      settle();
      d_exp = df_edges(d_mode, d_edge, d_prev, d_new);
      rd(4'd10, rv);
      chk("R11 pending", rv, {8'b0, d_exp});
      chk("R8 irq df", irq, |(d_exp & d_mask));
      chk("R9 tx", df_tx_pin, (d_mode & d_out) | (~d_mode & d_stx));
      chk("R10 ser_rx", ser_rx, d_mode | d_new);
      rd(4'd8, rv);
      chk("R10 level", rv, {8'b0, d_new});
      wr(4'd10, 16'h00FF);
      rd(4'd10, rv);
      chk("R7 df cleared", rv, 0);
      d_prev = d_new;
    end

    finish_run();
  end
endmodule